// File: doc/BRIEF.md
# Input Capture Channel with Edge-Triggered Counter Latches

This block watches one external pin and records when it changes level. It synchronizes the pin to the local clock. It can gate the pin off, which forces the level to 0, and it can invert the level. A rising edge of the resulting signal copies the value on the free-running counter input into a rise-latch register. A falling edge copies it into a fall-latch register. The counter is generated elsewhere. This block only samples it.

Each latch has its own "latched" indicator bit. One capture flag, with separate enables for rising and falling edges, drives the interrupt line. A single control bit chooses how software clears the indicator bits: by writing 0 to them, or by writing 1 to them. Software uses a small register port for control and status, and reads the two latch values through the same port.

Top module: `edge_capture_channel`

## Requirements
- R1: After reset, the control register, both latch registers, both indicator bits and the capture flag read 0, and `irq_o` is low.
- R2: With capture enabled (control bit 3), a rising edge of the conditioned input loads `count_i` into the rise latch (read address 2) and sets the rise indicator (status bit 1).
- R3: With capture enabled, a falling edge of the conditioned input loads `count_i` into the fall latch (read address 3) and sets the fall indicator (status bit 2).
- R4: When the invert bit (control bit 0) is 1, the pin level is reversed before edge detection. Changing the invert bit therefore produces an edge of its own.
- R5: When the input-path enable (control bit 4) is 0, the conditioned input is the invert bit alone, so the pin has no effect. Switching the path off while the level is high gives a falling edge.
- R6: When capture is disabled, neither latch updates, neither indicator sets, and `irq_o` stays low even while the capture flag is 1.
- R7: The capture flag (status bit 0) sets on a captured rising edge only if the rising enable (control bit 1) is 1, and on a captured falling edge only if the falling enable (control bit 2) is 1. `irq_o` equals the flag while capture is enabled.
- R8: Writing status with bit 0 set clears the capture flag. Writing bit 0 as 0 leaves the flag unchanged.
- R9: With the clear-select bit (control bit 5) at 0, writing 0 to an indicator clears it and writing 1 keeps it. With the clear-select bit at 1, writing 1 clears it and writing 0 keeps it.
- R10: When a hardware set and a software clear of the flag or of an indicator fall on the same clock edge, the bit ends up set.
- R11: The pin passes through a two-stage synchronizer. A pin change that first meets clock edge k is latched at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W | Current value of the external down counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status) |
| wr_data | input | 6 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 status, 2 rise latch, 3 fall latch) |
| rd_data | output | CNT_W | Read data, zero-extended |
| irq_o | output | 1 | Capture interrupt |

## Verification
A captured edge can set the flag and an indicator on the same clock edge at which software writes the status register to clear them. The bench finds that edge by counting synchronizer stages from a pin change. It holds the clearing write across exactly that clock edge and then reads status, expecting the flag and the indicator to be set. The same sequence reads the fall latch one cycle early and then on time, which pins down the synchronizer latency.

// File: rtl/cap_chan_pkg.sv
package cap_chan_pkg;

   localparam int ADDR_W = 2;
   localparam int CFG_W  = 6;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_RISE = 2'd2,
      REG_FALL = 2'd3
   } cap_reg_e;

   // bit 0 invert ... bit 5 clear-select
   typedef struct packed {
      logic clr_on_one;
      logic path_en;
      logic cap_en;
      logic fall_ie;
      logic rise_ie;
      logic invert;
   } cap_ctrl_t;

   localparam int ST_FLAG = 0;
   localparam int ST_RISE = 1;
   localparam int ST_FALL = 2;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("cap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[i] <= 1'b0;
         else if (i == 0)
            chain[i] <= d_i;
         else
            chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic path_en,
   input  logic invert,
   output logic rise_o,
   output logic fall_o
);
   logic level;
   logic level_q;

   assign level = (sync_i & path_en) ^ invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_q <= 1'b0;
      else
         level_q <= level;
   end

   assign rise_o = level & ~level_q;
   assign fall_o = ~level & level_q;
endmodule

// File: rtl/cap_regs.sv
module cap_regs
   import cap_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CNT_W-1:0]      count_i,
   input  logic                  rise_evt,
   input  logic                  fall_evt,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CFG_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [CNT_W-1:0]      rd_data,
   output cap_ctrl_t             ctrl_o,
   output logic                  flag_o,
   output logic                  rise_ind_o,
   output logic                  fall_ind_o,
   output logic [CNT_W-1:0]      rise_q_o,
   output logic [CNT_W-1:0]      fall_q_o
);
   if (CNT_W < CFG_W) begin : g_bad
      $error("cap_regs: CNT_W must be at least CFG_W");
   end

   cap_ctrl_t        ctrl_q;
   logic             flag_q, rise_ind_q, fall_ind_q;
   logic [CNT_W-1:0] rise_q, fall_q;

   logic wr_ctrl, wr_stat;
   logic take_rise, take_fall, set_flag;
   logic clr_flag, clr_rise, clr_fall;

   assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
   assign wr_stat   = wr_en && (wr_addr == REG_STAT);
   assign take_rise = rise_evt & ctrl_q.cap_en;
   assign take_fall = fall_evt & ctrl_q.cap_en;
   assign set_flag  = (take_rise & ctrl_q.rise_ie) | (take_fall & ctrl_q.fall_ie);
   assign clr_flag  = wr_stat & wr_data[ST_FLAG];
   assign clr_rise  = wr_stat & (wr_data[ST_RISE] == ctrl_q.clr_on_one);
   assign clr_fall  = wr_stat & (wr_data[ST_FALL] == ctrl_q.clr_on_one);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         flag_q     <= 1'b0;
         rise_ind_q <= 1'b0;
         fall_ind_q <= 1'b0;
         rise_q     <= '0;
         fall_q     <= '0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= cap_ctrl_t'(wr_data);

         if (set_flag)      flag_q <= 1'b1;
         else if (clr_flag) flag_q <= 1'b0;

         if (take_rise)     rise_ind_q <= 1'b1;
         else if (clr_rise) rise_ind_q <= 1'b0;

         if (take_fall)     fall_ind_q <= 1'b1;
         else if (clr_fall) fall_ind_q <= 1'b0;

         if (take_rise) rise_q <= count_i;
         if (take_fall) fall_q <= count_i;
      end
   end

   always_comb begin
      rd_data = '0;
      case (cap_reg_e'(rd_addr))
         REG_CTRL: rd_data[CFG_W-1:0] = ctrl_q;
         REG_STAT: begin
            rd_data[ST_FLAG] = flag_q;
            rd_data[ST_RISE] = rise_ind_q;
            rd_data[ST_FALL] = fall_ind_q;
         end
         REG_RISE: rd_data = rise_q;
         REG_FALL: rd_data = fall_q;
         default:  rd_data = '0;
      endcase
   end

   assign ctrl_o     = ctrl_q;
   assign flag_o     = flag_q;
   assign rise_ind_o = rise_ind_q;
   assign fall_ind_o = fall_ind_q;
   assign rise_q_o   = rise_q;
   assign fall_q_o   = fall_q;
endmodule

// File: rtl/edge_capture_channel.sv
module edge_capture_channel
   import cap_chan_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [5:0]        wr_data,
   input  logic [1:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              irq_o
);
   logic             pin_sync;
   logic             rise_evt, fall_evt;
   cap_ctrl_t        ctrl;
   logic             cap_en;
   logic             flag, rise_ind, fall_ind;
   logic [CNT_W-1:0] rise_q, fall_q;

   cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   cap_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (pin_sync),
      .path_en (ctrl.path_en),
      .invert  (ctrl.invert),
      .rise_o  (rise_evt),
      .fall_o  (fall_evt)
   );

   cap_regs #(.CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .count_i    (count_i),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .ctrl_o     (ctrl),
      .flag_o     (flag),
      .rise_ind_o (rise_ind),
      .fall_ind_o (fall_ind),
      .rise_q_o   (rise_q),
      .fall_q_o   (fall_q)
   );

   assign cap_en = ctrl.cap_en;
   assign irq_o  = flag & cap_en;
endmodule

// File: rtl/edge_capture_checker.sv
module edge_capture_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic             rise_evt,
   input logic             fall_evt,
   input logic             cap_en,
   input logic             rise_ind,
   input logic             fall_ind,
   input logic [CNT_W-1:0] rise_q,
   input logic [CNT_W-1:0] fall_q,
   input logic             irq_o
);
   // R2: edge events are never both active
   a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_evt && fall_evt));

   // R2: captured rising edge loads counter and sets indicator (R10 set wins)
   a_r2_rise_load: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_evt && cap_en) |=> (rise_q == $past(count_i)) && rise_ind);

   // R3: captured falling edge loads counter and sets indicator
   a_r3_fall_load: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && cap_en) |=> (fall_q == $past(count_i)) && fall_ind);

   // R6: latches hold while capture is off
   a_r6_latches_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(rise_q) && $stable(fall_q));

   // R6: interrupt masked while capture is off
   a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |-> !irq_o);
endmodule

bind edge_capture_channel edge_capture_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .count_i  (count_i),
   .rise_evt (rise_evt),
   .fall_evt (fall_evt),
   .cap_en   (cap_en),
   .rise_ind (rise_ind),
   .fall_ind (fall_ind),
   .rise_q   (rise_q),
   .fall_q   (fall_q),
   .irq_o    (irq_o)
);

// File: tb/edge_capture_channel_test.sv
module edge_capture_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_i = 1'b0;
   logic [15:0] count_i = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [5:0]  wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   edge_capture_channel uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .count_i(count_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
   );

   typedef struct packed {
      logic        pin;
      logic [15:0] cnt;
      logic [15:0] exp_rise;
      logic [15:0] exp_fall;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b1, 16'h1234, 16'h1234, 16'h0000},
      '{1'b0, 16'hBEEF, 16'h1234, 16'hBEEF},
      '{1'b0, 16'h0001, 16'h1234, 16'hBEEF},
      '{1'b1, 16'hFFFF, 16'hFFFF, 16'hBEEF},
      '{1'b1, 16'h7777, 16'hFFFF, 16'hBEEF},
      '{1'b0, 16'h0000, 16'hFFFF, 16'h0000}
   };

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [5:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic drive(input logic p, input logic [15:0] c);
      @(negedge clk);
      pin_i = p; count_i = c;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
      rd(2'd1, v); chk("R1 status", v, 16'h0);
      rd(2'd2, v); chk("R1 rise latch", v, 16'h0);
      rd(2'd3, v); chk("R1 fall latch", v, 16'h0);
      chk("R1 irq", {15'd0, irq_o}, 16'h0);

      // table: capture on, path on, both enables
      wr(2'd0, 6'h1E);
      foreach (VECS[i]) begin
         drive(VECS[i].pin, VECS[i].cnt);
         rd(2'd2, v); chk("R2 rise latch", v, VECS[i].exp_rise);
         rd(2'd3, v); chk("R3 fall latch", v, VECS[i].exp_fall);
      end
      rd(2'd1, v); chk("R7 status after edges", v, 16'h7);
      chk("R7 irq", {15'd0, irq_o}, 16'h1);

      // R8 flag clear by 1, indicators kept (write 1, clear-on-zero)
      wr(2'd1, 6'h07);
      rd(2'd1, v); chk("R8 flag cleared", v, 16'h6);
      chk("R8 irq low", {15'd0, irq_o}, 16'h0);
      // R9 clear-on-zero
      wr(2'd1, 6'h00);
      rd(2'd1, v); chk("R9 write-0 clears", v, 16'h0);

      // R9 clear-on-one
      wr(2'd0, 6'h3E);
      drive(1'b1, 16'h1111);
      drive(1'b0, 16'h2222);
      rd(2'd1, v); chk("R9 set before clear", v, 16'h7);
      wr(2'd1, 6'h00);
      rd(2'd1, v); chk("R9 write-0 keeps", v, 16'h7);
      wr(2'd1, 6'h02);
      rd(2'd1, v); chk("R9 write-1 clears rise", v, 16'h5);
      wr(2'd1, 6'h05);
      rd(2'd1, v); chk("R9 all clear", v, 16'h0);

      // R7 only rising enable
      wr(2'd0, 6'h1A);
      drive(1'b1, 16'h3333);
      rd(2'd1, v); chk("R7 rise sets flag", v, 16'h3);
      wr(2'd1, 6'h01);
      drive(1'b0, 16'h4444);
      rd(2'd1, v); chk("R7 fall no flag", v, 16'h4);
      rd(2'd3, v); chk("R7 fall latch", v, 16'h4444);

      // R4 invert: toggling invert with pin low gives a rise
      @(negedge clk); count_i = 16'h0A0A;
      wr(2'd0, 6'h1F);
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R4 invert rise", v, 16'h0A0A);
      drive(1'b1, 16'h0B0B);
      rd(2'd3, v); chk("R4 inverted fall", v, 16'h0B0B);

      // R5 path disable forces 0
      @(negedge clk); count_i = 16'h0C0C;
      wr(2'd0, 6'h1E);
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R5 level high", v, 16'h0C0C);
      @(negedge clk); count_i = 16'h0D0D;
      wr(2'd0, 6'h0E);
      repeat (3) @(negedge clk);
      rd(2'd3, v); chk("R5 path off falls", v, 16'h0D0D);
      drive(1'b0, 16'h0E0E);
      drive(1'b1, 16'h0F0F);
      rd(2'd2, v); chk("R5 rise ignored", v, 16'h0C0C);
      rd(2'd3, v); chk("R5 fall ignored", v, 16'h0D0D);

      // R6 capture disabled
      @(negedge clk); count_i = 16'h1010;
      wr(2'd0, 6'h1E);
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R6 precondition rise", v, 16'h1010);
      wr(2'd0, 6'h16);
      wr(2'd1, 6'h00);
      rd(2'd1, v); chk("R6 flag kept", v, 16'h1);
      chk("R6 irq masked", {15'd0, irq_o}, 16'h0);
      drive(1'b0, 16'h2020);
      drive(1'b1, 16'h3030);
      rd(2'd1, v); chk("R6 no indicators", v, 16'h1);
      rd(2'd2, v); chk("R6 rise held", v, 16'h1010);
      rd(2'd3, v); chk("R6 fall held", v, 16'h0D0D);
      chk("R6 irq still masked", {15'd0, irq_o}, 16'h0);

      // R10 / R11: clear write on the same edge as the capture
      wr(2'd0, 6'h1E);
      wr(2'd1, 6'h01);
      rd(2'd1, v); chk("R10 precondition", v, 16'h0);
      @(negedge clk);
      count_i = 16'h5A5A; pin_i = 1'b0; rd_addr = 2'd3;
      @(negedge clk);
      @(negedge clk);
      #1 chk("R11 not yet latched", rd_data, 16'h0D0D);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 6'h01;
      @(negedge clk);
      wr_en = 1'b0;
      #1 chk("R11 latched at third edge", rd_data, 16'h5A5A);
      rd(2'd1, v); chk("R10 set wins", v, 16'h5);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule